// File: doc/BRIEF.md
# Four-Channel DMA Programming Register File

This block is the processor-facing register set of a four-channel DMA controller whose data port is one byte wide. The processor reaches it through a sixteen-location I/O window. It programs each channel's 16-bit start address and 16-bit transfer count, sets per-channel mode and mask bits, issues software requests, and reads back status and residual values. The transfer engine reads the stored values, the masks and the modes from this block. That engine writes updated current values back, and it signals terminal count for each channel.

All 16-bit quantities pass through the 8-bit port as two accesses to the same offset, low byte first. A single byte-pointer state machine is shared by every channel and every field, and it decides which byte an access reaches. It has two states, `PTR_LOW` and `PTR_HIGH`. The *toggle* transition swaps the state on every channel access. The *clear* transition forces `PTR_LOW` on a pointer-clear write or a master-clear write, and it takes priority over the toggle.

Top module: `dma_regfile`

## Requirements
- R1: After reset, all four mask bits are 1, the byte pointer is in PTR_LOW, and the command, request, status, mode, address, count and read-data registers are all 0.
- R2: A write to offset 2n (n = 0..3) loads one byte of channel n's base and current address. A write to offset 2n+1 does the same for the count. The byte pointer selects bits 7:0 in PTR_LOW and bits 15:8 in PTR_HIGH. The current register takes the updated base value.
- R3: A read of offset 2n or 2n+1 returns, on bus_rdata one clock later, the byte of channel n's current address or count that the pointer selects. Every access to offsets 0x0 to 0x7 toggles the pointer. A read of offsets 0x9, 0xA, 0xB, 0xC, 0xE or 0xF returns 0x00 and leaves the pointer unchanged.
- R4: Any write to offset 0xC returns the pointer to PTR_LOW, so the next channel access reaches the low byte.
- R5: A write to offset 0xA selects channel data[1:0]. It sets that channel's mask when data[2] is 1 and clears it when data[2] is 0. The other masks are unchanged.
- R6: A write to offset 0xB stores data[7:2] as the mode of channel data[1:0], exported on ch_mode[6n+5:6n]. Auto-initialise is data bit 4, and cascade is indicated when data[7:6] is 2'b11.
- R7: A write to offset 0xE clears all four masks. A write to offset 0xF loads all four masks from data[3:0], with bit n belonging to channel n.
- R8: A write to offset 0xD (master clear) sets all masks, returns the pointer to PTR_LOW, and clears the command, request and status registers. Address and count registers are unchanged. A read of offset 0xD returns 0x00.
- R9: A write to offset 0x8 stores the command byte. A read of offset 0x8 returns status: bits 3:0 are the terminal-count flags of channels 3..0, and bits 7:4 are dreq OR the software request, per channel. The read clears the flags. A terminal count arriving in the same cycle as the read is not returned by that read, and its flag stays set.
- R10: A write to offset 0x9 sets (data[2]=1) or clears (data[2]=0) the software request of channel data[1:0].
- R11: wb_en[n] loads wb_addr and wb_count into channel n's current registers and leaves its base registers unchanged. A processor write to a field in the same cycle takes precedence for that field.
- R12: A tc_pulse[n] on a channel whose auto-initialise bit is set reloads both current registers from the base registers. Without auto-initialise, the current registers keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_cs | input | 1 | Access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after a read |
| tc_pulse | input | 4 | Terminal-count pulse per channel from the engine |
| dreq | input | 4 | Hardware request per channel |
| wb_en | input | 4 | Current-value write-back enable per channel |
| wb_addr | input | 16 | Write-back current address |
| wb_count | input | 16 | Write-back current count |
| ch_mask | output | 4 | Mask bit per channel |
| ch_mode | output | 24 | Six-bit mode per channel, channel n at [6n+5:6n] |
| ch_autoinit | output | 4 | Auto-initialise enable per channel |
| ch_cascade | output | 4 | Cascade mode per channel |
| ch_base_addr | output | 64 | Base addresses, channel n at [16n+15:16n] |
| ch_base_count | output | 64 | Base counts |
| ch_cur_addr | output | 64 | Current addresses |
| ch_cur_count | output | 64 | Current counts |
| cmd_reg | output | 8 | Command byte |
| sw_req | output | 4 | Software request per channel |

## Verification
The bench writes a single byte, clears the pointer, and then writes a full pair. A pointer that ignored the clear would put the second byte into the high half. It reads a write-only offset between the two halves of a readback, which catches a pointer that toggles on every access. It raises a terminal count in the same cycle as a status read, which catches a design where clear-on-read wipes the new flag. It performs a master clear while the pointer is in PTR_HIGH, which exposes a design that keeps stale pointer state or erases channel addresses. It also contrasts write-back and terminal count on an auto-initialising channel with the same sequence on a plain channel, which shows whether a reload is wrongly taken or wrongly skipped.

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;
    localparam int NCH    = 4;
    localparam int CHW    = $clog2(NCH);
    localparam int DW     = 8;
    localparam int VW     = 2 * DW;
    localparam int AW     = 4;
    localparam int MODEW  = DW - CHW;

    // bit positions inside the stored mode field (data bits shifted down by CHW)
    localparam int MODE_AUTO_BIT = 4 - CHW;
    localparam int MODE_XFER_LSB = 6 - CHW;

    localparam logic [AW-1:0] OFF_CMD     = 4'h8;
    localparam logic [AW-1:0] OFF_REQ     = 4'h9;
    localparam logic [AW-1:0] OFF_SMASK   = 4'hA;
    localparam logic [AW-1:0] OFF_MODE    = 4'hB;
    localparam logic [AW-1:0] OFF_PTRCLR  = 4'hC;
    localparam logic [AW-1:0] OFF_MCLR    = 4'hD;
    localparam logic [AW-1:0] OFF_CLRMASK = 4'hE;
    localparam logic [AW-1:0] OFF_ALLMASK = 4'hF;

    localparam logic [DW-1:0] TEMP_VALUE  = '0;
    localparam int            SET_BIT     = 2;

    typedef enum logic {
        PTR_LOW  = 1'b0,
        PTR_HIGH = 1'b1
    } ptr_state_t;

    typedef struct packed {
        logic           ch_wr;
        logic           ch_rd;
        logic [CHW-1:0] ch_sel;
        logic           is_cnt;
        logic           cmd_wr;
        logic           stat_rd;
        logic           req_wr;
        logic           smask_wr;
        logic           mode_wr;
        logic           ptrclr_wr;
        logic           mclr_wr;
        logic           temp_rd;
        logic           clrmask_wr;
        logic           allmask_wr;
    } dec_t;
endpackage

// File: rtl/dmareg_decode.sv
module dmareg_decode
    import dmareg_pkg::*;
(
    input  logic          cs,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    output dec_t          dec
);
    always_comb begin
        dec = '0;
        if (cs) begin
            if (!addr[AW-1]) begin
                dec.ch_sel = addr[CHW:1];
                dec.is_cnt = addr[0];
                dec.ch_wr  = wr;
                dec.ch_rd  = !wr;
            end else begin
                case (addr)
                    OFF_CMD: begin
                        dec.cmd_wr  = wr;
                        dec.stat_rd = !wr;
                    end
                    OFF_REQ:     dec.req_wr     = wr;
                    OFF_SMASK:   dec.smask_wr   = wr;
                    OFF_MODE:    dec.mode_wr    = wr;
                    OFF_PTRCLR:  dec.ptrclr_wr  = wr;
                    OFF_MCLR: begin
                        dec.mclr_wr = wr;
                        dec.temp_rd = !wr;
                    end
                    OFF_CLRMASK: dec.clrmask_wr = wr;
                    OFF_ALLMASK: dec.allmask_wr = wr;
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/dmareg_byteptr.sv
module dmareg_byteptr
    import dmareg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic toggle,
    output logic high
);
    ptr_state_t state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= PTR_LOW;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (clr) begin
            state_nx = PTR_LOW;
        end else if (toggle) begin
            unique case (state)
                PTR_LOW:  state_nx = PTR_HIGH;
                PTR_HIGH: state_nx = PTR_LOW;
            endcase
        end
    end

    always_comb begin
        high = (state == PTR_HIGH);
    end

    // R4
    ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !high);

    // R3
    ptr_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (toggle && !clr) |=> (high != $past(high)));
endmodule

// File: rtl/dmareg_channel.sv
module dmareg_channel
    import dmareg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          addr_we,
    input  logic          cnt_we,
    input  logic          hi_byte,
    input  logic [DW-1:0] wdata,
    input  logic          reload,
    input  logic          wb_en,
    input  logic [VW-1:0] wb_addr,
    input  logic [VW-1:0] wb_cnt,
    output logic [VW-1:0] base_addr,
    output logic [VW-1:0] base_cnt,
    output logic [VW-1:0] cur_addr,
    output logic [VW-1:0] cur_cnt
);
    logic [VW-1:0] addr_nx, cnt_nx;

    always_comb begin
        addr_nx = hi_byte ? {wdata, base_addr[VW-DW-1:0]} : {base_addr[VW-1:DW], wdata};
        cnt_nx  = hi_byte ? {wdata, base_cnt[VW-DW-1:0]}  : {base_cnt[VW-1:DW], wdata};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_addr <= '0;
            cur_addr  <= '0;
        end else if (addr_we) begin
            base_addr <= addr_nx;
            cur_addr  <= addr_nx;
        end else if (reload) begin
            cur_addr  <= base_addr;
        end else if (wb_en) begin
            cur_addr  <= wb_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_cnt <= '0;
            cur_cnt  <= '0;
        end else if (cnt_we) begin
            base_cnt <= cnt_nx;
            cur_cnt  <= cnt_nx;
        end else if (reload) begin
            cur_cnt  <= base_cnt;
        end else if (wb_en) begin
            cur_cnt  <= wb_cnt;
        end
    end

    // R11
    wb_base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en && !reload && !addr_we && !cnt_we) |=>
            (base_addr == $past(base_addr) && base_cnt == $past(base_cnt) &&
             cur_addr == $past(wb_addr) && cur_cnt == $past(wb_cnt)));

    // R12
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reload && !addr_we && !cnt_we) |=>
            (cur_addr == $past(base_addr) && cur_cnt == $past(base_cnt)));
endmodule

// File: rtl/dmareg_ctrl.sv
module dmareg_ctrl
    import dmareg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  dec_t                 dec,
    input  logic [DW-1:0]        wdata,
    input  logic [NCH-1:0]       tc_pulse,
    input  logic [NCH-1:0]       dreq,
    output logic [NCH-1:0]       mask,
    output logic [NCH*MODEW-1:0] mode_flat,
    output logic [NCH-1:0]       autoinit,
    output logic [NCH-1:0]       cascade,
    output logic [DW-1:0]        cmd,
    output logic [NCH-1:0]       req,
    output logic [DW-1:0]        status
);
    logic [NCH-1:0] tc_flag;
    logic [CHW-1:0] sel;

    assign sel = wdata[CHW-1:0];

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic             mask_r, req_r, tc_r;
        logic [MODEW-1:0] mode_r;
        logic             hit;

        assign hit = (sel == CHW'(g));

        always_ff @(posedge clk) begin
            if (!rst_n)                       mask_r <= 1'b1;
            else if (dec.mclr_wr)             mask_r <= 1'b1;
            else if (dec.clrmask_wr)          mask_r <= 1'b0;
            else if (dec.allmask_wr)          mask_r <= wdata[g];
            else if (dec.smask_wr && hit)     mask_r <= wdata[SET_BIT];
        end

        always_ff @(posedge clk) begin
            if (!rst_n)                       req_r <= 1'b0;
            else if (dec.mclr_wr)             req_r <= 1'b0;
            else if (dec.req_wr && hit)       req_r <= wdata[SET_BIT];
        end

        always_ff @(posedge clk) begin
            if (!rst_n)                       tc_r <= 1'b0;
            else if (dec.mclr_wr)             tc_r <= 1'b0;
            else if (tc_pulse[g])             tc_r <= 1'b1;
            else if (dec.stat_rd)             tc_r <= 1'b0;
        end

        always_ff @(posedge clk) begin
            if (!rst_n)                       mode_r <= '0;
            else if (dec.mode_wr && hit)      mode_r <= wdata[DW-1:CHW];
        end

        assign mask[g]                   = mask_r;
        assign req[g]                    = req_r;
        assign tc_flag[g]                = tc_r;
        assign mode_flat[g*MODEW +: MODEW] = mode_r;
        assign autoinit[g]               = mode_r[MODE_AUTO_BIT];
        assign cascade[g]                = &mode_r[MODE_XFER_LSB +: 2];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)           cmd <= '0;
        else if (dec.mclr_wr) cmd <= '0;
        else if (dec.cmd_wr)  cmd <= wdata;
    end

    assign status = {dreq | req, tc_flag};

    // R8
    mclr_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec.mclr_wr |=> (mask == {NCH{1'b1}} && cmd == '0 && req == '0));

    // R7
    clrmask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec.clrmask_wr && !dec.mclr_wr) |=> (mask == '0));

    // R9
    tc_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_pulse[0] && !dec.mclr_wr) |=> status[0]);
endmodule

// File: rtl/dma_regfile.sv
module dma_regfile
    import dmareg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_cs,
    input  logic                 bus_wr,
    input  logic [AW-1:0]        bus_addr,
    input  logic [DW-1:0]        bus_wdata,
    output logic [DW-1:0]        bus_rdata,
    input  logic [NCH-1:0]       tc_pulse,
    input  logic [NCH-1:0]       dreq,
    input  logic [NCH-1:0]       wb_en,
    input  logic [VW-1:0]        wb_addr,
    input  logic [VW-1:0]        wb_count,
    output logic [NCH-1:0]       ch_mask,
    output logic [NCH*MODEW-1:0] ch_mode,
    output logic [NCH-1:0]       ch_autoinit,
    output logic [NCH-1:0]       ch_cascade,
    output logic [NCH*VW-1:0]    ch_base_addr,
    output logic [NCH*VW-1:0]    ch_base_count,
    output logic [NCH*VW-1:0]    ch_cur_addr,
    output logic [NCH*VW-1:0]    ch_cur_count,
    output logic [DW-1:0]        cmd_reg,
    output logic [NCH-1:0]       sw_req
);
    dec_t          dec;
    logic          ptr_high;
    logic [DW-1:0] status;
    logic [VW-1:0] cur_addr_a [NCH];
    logic [VW-1:0] cur_cnt_a  [NCH];
    logic [VW-1:0] sel_val;

    dmareg_decode u_dec (
        .cs   (bus_cs),
        .wr   (bus_wr),
        .addr (bus_addr),
        .dec  (dec)
    );

    dmareg_byteptr u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (dec.ptrclr_wr | dec.mclr_wr),
        .toggle (dec.ch_wr | dec.ch_rd),
        .high   (ptr_high)
    );

    dmareg_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .dec       (dec),
        .wdata     (bus_wdata),
        .tc_pulse  (tc_pulse),
        .dreq      (dreq),
        .mask      (ch_mask),
        .mode_flat (ch_mode),
        .autoinit  (ch_autoinit),
        .cascade   (ch_cascade),
        .cmd       (cmd_reg),
        .req       (sw_req),
        .status    (status)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        logic addr_we, cnt_we;
        assign addr_we = dec.ch_wr && !dec.is_cnt && (dec.ch_sel == CHW'(g));
        assign cnt_we  = dec.ch_wr &&  dec.is_cnt && (dec.ch_sel == CHW'(g));

        dmareg_channel u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .addr_we   (addr_we),
            .cnt_we    (cnt_we),
            .hi_byte   (ptr_high),
            .wdata     (bus_wdata),
            .reload    (tc_pulse[g] & ch_autoinit[g]),
            .wb_en     (wb_en[g]),
            .wb_addr   (wb_addr),
            .wb_cnt    (wb_count),
            .base_addr (ch_base_addr[g*VW +: VW]),
            .base_cnt  (ch_base_count[g*VW +: VW]),
            .cur_addr  (cur_addr_a[g]),
            .cur_cnt   (cur_cnt_a[g])
        );

        assign ch_cur_addr[g*VW +: VW]  = cur_addr_a[g];
        assign ch_cur_count[g*VW +: VW] = cur_cnt_a[g];
    end

    assign sel_val = dec.is_cnt ? cur_cnt_a[dec.ch_sel] : cur_addr_a[dec.ch_sel];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_cs && !bus_wr) begin
            if (dec.ch_rd)        bus_rdata <= ptr_high ? sel_val[VW-1:DW] : sel_val[DW-1:0];
            else if (dec.stat_rd) bus_rdata <= status;
            else if (dec.temp_rd) bus_rdata <= TEMP_VALUE;
            else                  bus_rdata <= '0;
        end
    end

    // R10
    req_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec.req_wr && bus_wdata[SET_BIT] && !dec.mclr_wr) |=> sw_req[$past(bus_wdata[CHW-1:0])]);

    // R5
    smask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec.smask_wr |=> (ch_mask[$past(bus_wdata[CHW-1:0])] == $past(bus_wdata[SET_BIT])));
endmodule

// File: tb/dma_regfile_test.sv
`timescale 1ns/1ps
module dma_regfile_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_cs = 1'b0, bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [3:0]  tc_pulse = '0, dreq = '0, wb_en = '0;
    logic [15:0] wb_addr = '0, wb_count = '0;
    logic [3:0]  ch_mask, ch_autoinit, ch_cascade, sw_req;
    logic [23:0] ch_mode;
    logic [63:0] ch_base_addr, ch_base_count, ch_cur_addr, ch_cur_count;
    logic [7:0]  cmd_reg;
    int checks = 0, errors = 0;
    logic [7:0] v;

    always #2.5 clk = ~clk;

    dma_regfile uut (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] off, input logic [7:0] d);
        @(negedge clk); bus_cs = 1; bus_wr = 1; bus_addr = off; bus_wdata = d;
        @(negedge clk); bus_cs = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [3:0] off, output logic [7:0] d);
        @(negedge clk); bus_cs = 1; bus_wr = 0; bus_addr = off;
        @(negedge clk); bus_cs = 0; d = bus_rdata;
    endtask

    task automatic pulse_tc(input logic [3:0] m);
        @(negedge clk); tc_pulse = m;
        @(negedge clk); tc_pulse = '0;
    endtask

    task automatic t_reset;
        chk("R1 mask", ch_mask, 4'hF);
        chk("R1 cmd", cmd_reg, 0);
        chk("R1 req", sw_req, 0);
        chk("R1 cur addr", ch_cur_addr, 0);
        chk("R1 rdata", bus_rdata, 0);
        rd(4'h8, v); chk("R1 status", v, 0);
    endtask

    task automatic t_addr_count;
        wr(4'h4, 8'h34); wr(4'h4, 8'h12);
        wr(4'h5, 8'hFF); wr(4'h5, 8'h00);
        chk("R2 base addr ch2", ch_base_addr[47:32], 16'h1234);
        chk("R2 cur addr ch2", ch_cur_addr[47:32], 16'h1234);
        chk("R2 base count ch2", ch_base_count[47:32], 16'h00FF);
        chk("R2 ch0 untouched", ch_base_addr[15:0], 0);
        rd(4'h4, v); chk("R3 read low", v, 8'h34);
        rd(4'h4, v); chk("R3 read high", v, 8'h12);
        rd(4'h5, v); chk("R3 count low", v, 8'hFF);
        rd(4'h5, v); chk("R3 count high", v, 8'h00);
    endtask

    task automatic t_ptr_clear;
        wr(4'h0, 8'hAA);
        wr(4'hC, 8'h00);
        wr(4'h0, 8'hBB); wr(4'h0, 8'hCC);
        chk("R4 ptr clear", ch_base_addr[15:0], 16'hCCBB);
    endtask

    task automatic t_unmapped_read;
        rd(4'h4, v);
        rd(4'hA, v); chk("R3 write-only read", v, 0);
        rd(4'h4, v); chk("R3 no toggle on unmapped", v, 8'h12);
    endtask

    task automatic t_mask;
        wr(4'hE, 8'h00); chk("R7 clear all", ch_mask, 4'h0);
        wr(4'hA, 8'h05); chk("R5 set ch1", ch_mask, 4'h2);
        wr(4'hA, 8'h07); chk("R5 set ch3", ch_mask, 4'hA);
        wr(4'hA, 8'h01); chk("R5 clear ch1", ch_mask, 4'h8);
        wr(4'hF, 8'hF9); chk("R7 write all", ch_mask, 4'h9);
    endtask

    task automatic t_mode;
        wr(4'hB, 8'hD3);
        chk("R6 mode ch3", ch_mode[23:18], 6'h34);
        chk("R6 cascade ch3", ch_cascade, 4'h8);
        chk("R6 autoinit ch3", ch_autoinit, 4'h8);
        wr(4'hB, 8'h11);
        chk("R6 mode ch1", ch_mode[11:6], 6'h04);
        chk("R6 autoinit ch1", ch_autoinit, 4'hA);
        chk("R6 cascade ch1 off", ch_cascade, 4'h8);
    endtask

    task automatic t_cmd_status_req;
        wr(4'h8, 8'h5A); chk("R9 cmd", cmd_reg, 8'h5A);
        wr(4'h9, 8'h06); chk("R10 req set ch2", sw_req, 4'h4);
        dreq = 4'h1;
        rd(4'h8, v); chk("R9 status requests", v, 8'h50);
        pulse_tc(4'h8);
        rd(4'h8, v); chk("R9 status tc3", v, 8'h58);
        rd(4'h8, v); chk("R9 clear on read", v, 8'h50);
        wr(4'h9, 8'h02); chk("R10 req clear ch2", sw_req, 4'h0);
        dreq = 4'h0;
    endtask

    task automatic t_tc_during_read;
        @(negedge clk); bus_cs = 1; bus_wr = 0; bus_addr = 4'h8; tc_pulse = 4'h1;
        @(negedge clk); bus_cs = 0; tc_pulse = 0; v = bus_rdata;
        chk("R9 same-cycle read excludes new flag", v, 8'h00);
        rd(4'h8, v); chk("R9 same-cycle flag survives", v, 8'h01);
    endtask

    task automatic t_wb_reload;
        wr(4'hC, 0);
        wr(4'h2, 8'h00); wr(4'h2, 8'h10);
        wr(4'h3, 8'h10); wr(4'h3, 8'h00);
        @(negedge clk); wb_en = 4'h2; wb_addr = 16'h2000; wb_count = 16'h0005;
        @(negedge clk); wb_en = 0;
        chk("R11 cur addr", ch_cur_addr[31:16], 16'h2000);
        chk("R11 cur count", ch_cur_count[31:16], 16'h0005);
        chk("R11 base kept", ch_base_addr[31:16], 16'h1000);
        pulse_tc(4'h2);
        chk("R12 reload addr", ch_cur_addr[31:16], 16'h1000);
        chk("R12 reload count", ch_cur_count[31:16], 16'h0010);
        @(negedge clk); wb_en = 4'h4; wb_addr = 16'h3333; wb_count = 16'h0007;
        @(negedge clk); wb_en = 0;
        pulse_tc(4'h4);
        chk("R12 no reload without autoinit", ch_cur_addr[47:32], 16'h3333);
        rd(4'h8, v);
    endtask

    task automatic t_mclr;
        wr(4'hE, 0); wr(4'h8, 8'h33); wr(4'h9, 8'h05);
        pulse_tc(4'h4);
        wr(4'h6, 8'h77);
        wr(4'hD, 8'h00);
        chk("R8 masks set", ch_mask, 4'hF);
        chk("R8 cmd cleared", cmd_reg, 0);
        chk("R8 req cleared", sw_req, 0);
        chk("R8 addr kept", ch_base_addr[47:32], 16'h1234);
        chk("R8 count kept", ch_base_count[47:32], 16'h00FF);
        rd(4'h8, v); chk("R8 status cleared", v, 0);
        wr(4'h6, 8'h11); wr(4'h6, 8'h22);
        chk("R8 ptr low", ch_base_addr[63:48], 16'h2211);
        rd(4'hD, v); chk("R8 temp read", v, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset;
        t_addr_count;
        t_ptr_clear;
        t_unmapped_read;
        t_mask;
        t_mode;
        t_cmd_status_req;
        t_tc_during_read;
        t_wb_reload;
        t_mclr;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 20000);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule